// File: doc/BRIEF.md
# Multi-Lane Word-Burst Serial Flash Shifter

This block is the shift engine of a serial flash master. A one-cycle go pulse starts a burst of one to four words. Each word can be 8, 16, 24 or 32 bits wide, so a trailing fragment of one to three bytes can go out as a single narrower word. A burst moves over one, two or four data lanes, in a direction chosen per burst: toward the flash or from it. While the burst runs, the busy output is high. When busy falls, the engine is free again and the receive words can be read.

Chip select is not tied to bursts. It follows a held enable input, so one selection can span a command burst, an address burst and a data burst. Its active level can be chosen and is low by default. The serial clock is derived from the system clock by a divider. Data lines appear as separate out, output-enable and in vectors for a pad ring to combine.

Top module: `lane_burst_shifter`

## Requirements
- R1: After reset, busy, sclk and dataOe are 0, csOut is 1 (chip select inactive) and all receive words are 0.
- R2: Go is accepted only while idle. Busy rises on the clock after go and stays high for beats*2*clkDiv system clocks, or for beats clocks when clkDiv is 0. Here beats = (wordCnt+1)*(widthSel+1)*8 / lanes. A go pulse during a burst is ignored and changes neither the length nor the data of the running burst.
- R3: A burst of wordCnt+1 words sends the word at txWords index wordCnt first, then the next lower index, down to index 0. Within each word the most significant bit goes first.
- R4: widthSel codes 0, 1, 2 and 3 select 8, 16, 24 and 32 bits per word. A narrower word sends only the low bits of its transmit word.
- R5: laneMode 0 is single: dataOut[0] drives and dataIn[1] is sampled. Mode 1 is dual on lines 1:0, with line 1 carrying the more significant bit. Modes 2 and 3 are quad on lines 3:0, with line 3 most significant.
- R6: In an input burst, the first word captured lands at rxWords index wordCnt and later words at lower indices. Each word is right-aligned and zero-extended. Receive words not addressed by the burst keep their values.
- R7: During an output burst, dataOe is 0001, 0011 or 1111 for single, dual or quad. During an input burst and while idle, dataOe is 0. An output burst leaves every receive word unchanged.
- R8: sclk idles low and rises once per beat. A beat lasts 2*clkDiv system clocks, with data launched while sclk is low and sampled as it rises. With clkDiv 0, sclk is the inverted system clock gated by busy, giving one beat per system clock.
- R9: csOut is registered. On the clock after csEnable changes, csOut equals csEnable when csActiveHigh is 1 and its inverse otherwise, independent of bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, one cycle |
| txWords | input | 128 | Four transmit words, index i at bits 32*i+31:32*i |
| widthSel | input | 2 | Bits per word: 8, 16, 24, 32 |
| wordCnt | input | 2 | Number of words minus one |
| laneMode | input | 2 | 0 single, 1 dual, 2/3 quad |
| dirIn | input | 1 | 1 = receive burst, 0 = transmit burst |
| csEnable | input | 1 | Chip select request |
| csActiveHigh | input | 1 | Chip select polarity, 0 = active low |
| clkDiv | input | 8 | Serial clock divider |
| busy | output | 1 | Burst in progress |
| rxWords | output | 128 | Four receive words, same layout as txWords |
| csOut | output | 1 | Chip select to the flash |
| sclk | output | 1 | Serial clock |
| dataOut | output | 4 | Data line output values |
| dataOe | output | 4 | Data line output enables |
| dataIn | input | 4 | Data line input values |

## Verification
A wrong beat or word counter shows on the ports within the burst. The busy time differs from beats*2*clkDiv, and the number of sclk rising edges differs from the beat count, both by the end of that burst. A wrong word index shows as a transmit word in the wrong slot of the flash-side capture, or a receive word in the wrong rxWords slot, as soon as busy falls. Lane or direction state that is wrong appears at once as a disallowed dataOe pattern, or as bits shifted onto the wrong lines, in the first beat of the burst.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 4;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int WBITS_W   = $clog2(WORD_W) + 1;
  localparam int LANES     = 4;

  // control -> datapath strobes and burst configuration
  typedef struct packed {
    logic               start;
    logic               sample;
    logic               advance;
    logic               wordEnd;
    logic               lastWord;
    logic [IDX_W-1:0]   wordIdx;
    logic [1:0]         lgLanes;
    logic [WBITS_W-1:0] widthBits;
    logic               dirIn;
  } lbs_strobe_t;
endpackage

// File: rtl/lbs_ctrl.sv
module lbs_ctrl
  import lbs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               go,
  input  logic [1:0]         widthSel,
  input  logic [IDX_W-1:0]   wordCnt,
  input  logic [1:0]         laneMode,
  input  logic               dirIn,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               csEnable,
  input  logic               csActiveHigh,
  output lbs_strobe_t        stb,
  output logic               busy,
  output logic               sclk,
  output logic               csOut
);
  logic               busyQ, sclkQ, dirQ, csQ;
  logic [DIV_W-1:0]   halfCnt, divQ;
  logic [WBITS_W-1:0] beatCnt, widthQ, beatsPerWord;
  logic [IDX_W-1:0]   wordIdxQ;
  logic [1:0]         lgLanesQ, lgLanesIn;
  logic [WBITS_W-1:0] widthIn;
  logic               startNow, divZero, tick, rise, fall, wordEnd, lastWord;

  assign startNow     = go & ~busyQ;
  assign lgLanesIn    = (laneMode == 2'd0) ? 2'd0 : (laneMode == 2'd1) ? 2'd1 : 2'd2;
  assign widthIn      = {1'b0, widthSel, 3'b000} + WBITS_W'(8);
  assign divZero      = (divQ == '0);
  assign tick         = divZero | (halfCnt == divQ - DIV_W'(1));
  assign rise         = busyQ & tick & (divZero | ~sclkQ);
  assign fall         = busyQ & tick & (divZero | sclkQ);
  assign beatsPerWord = widthQ >> lgLanesQ;
  assign wordEnd      = fall & (beatCnt == beatsPerWord - WBITS_W'(1));
  assign lastWord     = (wordIdxQ == '0);

  always_comb begin
    stb           = '0;
    stb.start     = startNow;
    stb.sample    = rise;
    stb.advance   = fall;
    stb.wordEnd   = wordEnd;
    stb.lastWord  = lastWord;
    stb.wordIdx   = startNow ? wordCnt   : wordIdxQ;
    stb.lgLanes   = startNow ? lgLanesIn : lgLanesQ;
    stb.widthBits = startNow ? widthIn   : widthQ;
    stb.dirIn     = startNow ? dirIn     : dirQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      sclkQ    <= 1'b0;
      dirQ     <= 1'b0;
      csQ      <= 1'b1;
      halfCnt  <= '0;
      divQ     <= '0;
      beatCnt  <= '0;
      widthQ   <= WBITS_W'(8);
      wordIdxQ <= '0;
      lgLanesQ <= '0;
    end else begin
      csQ <= csActiveHigh ? csEnable : ~csEnable;
      if (startNow) begin
        busyQ    <= 1'b1;
        sclkQ    <= 1'b0;
        halfCnt  <= '0;
        divQ     <= clkDiv;
        beatCnt  <= '0;
        wordIdxQ <= wordCnt;
        lgLanesQ <= lgLanesIn;
        widthQ   <= widthIn;
        dirQ     <= dirIn;
      end else if (busyQ) begin
        if (!divZero) begin
          if (tick) begin
            halfCnt <= '0;
            sclkQ   <= ~sclkQ;
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        if (fall) begin
          if (wordEnd) begin
            beatCnt <= '0;
            if (lastWord) busyQ <= 1'b0;
            else          wordIdxQ <= wordIdxQ - IDX_W'(1);
          end else begin
            beatCnt <= beatCnt + WBITS_W'(1);
          end
        end
      end
    end
  end

  assign busy  = busyQ;
  assign sclk  = divZero ? (busyQ & ~clk) : sclkQ;
  assign csOut = csQ;
endmodule

// File: rtl/lbs_dpath.sv
module lbs_dpath
  import lbs_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  lbs_strobe_t                 stb,
  input  logic                        busy,
  input  logic [NUM_WORDS*WORD_W-1:0] txWords,
  input  logic [LANES-1:0]            dataIn,
  output logic [LANES-1:0]            dataOut,
  output logic [LANES-1:0]            dataOe,
  output logic [NUM_WORDS*WORD_W-1:0] rxWords
);
  logic [WORD_W-1:0] txHold [NUM_WORDS];
  logic [WORD_W-1:0] rxReg  [NUM_WORDS];
  logic [WORD_W-1:0] txSh, rxAcc, accNext, widthMask;
  logic [LANES-1:0]  laneBits, laneMask;
  logic [IDX_W-1:0]  prevIdx;
  logic              driving;

  function automatic logic [WORD_W-1:0] alignWord(input logic [WORD_W-1:0] w,
                                                  input logic [WBITS_W-1:0] wb);
    return w << (WBITS_W'(WORD_W) - wb);
  endfunction

  assign prevIdx   = stb.wordIdx - IDX_W'(1);
  assign widthMask = (stb.widthBits == WBITS_W'(WORD_W)) ? '1
                   : ((WORD_W'(1) << stb.widthBits) - WORD_W'(1));
  assign driving   = busy & ~stb.dirIn;

  always_comb begin
    unique case (stb.lgLanes)
      2'd0: begin
        laneBits = {3'b000, dataIn[1]};
        accNext  = {rxAcc[WORD_W-2:0], dataIn[1]};
        laneMask = 4'b0001;
        dataOut  = {3'b000, txSh[WORD_W-1]};
      end
      2'd1: begin
        laneBits = {2'b00, dataIn[1:0]};
        accNext  = {rxAcc[WORD_W-3:0], dataIn[1:0]};
        laneMask = 4'b0011;
        dataOut  = {2'b00, txSh[WORD_W-1 -: 2]};
      end
      default: begin
        laneBits = dataIn;
        accNext  = {rxAcc[WORD_W-5:0], dataIn};
        laneMask = 4'b1111;
        dataOut  = txSh[WORD_W-1 -: 4];
      end
    endcase
    if (!stb.sample) accNext = rxAcc;
    if (!driving) begin
      dataOut  = '0;
      laneMask = '0;
    end
    dataOe = laneMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh  <= '0;
      rxAcc <= '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
        txHold[i] <= '0;
        rxReg[i]  <= '0;
      end
    end else if (stb.start) begin
      for (int i = 0; i < NUM_WORDS; i++) txHold[i] <= txWords[i*WORD_W +: WORD_W];
      txSh  <= alignWord(txWords[stb.wordIdx*WORD_W +: WORD_W], stb.widthBits);
      rxAcc <= '0;
    end else begin
      rxAcc <= accNext;
      if (stb.wordEnd) begin
        if (stb.dirIn) rxReg[stb.wordIdx] <= accNext & widthMask;
        if (!stb.lastWord) txSh <= alignWord(txHold[prevIdx], stb.widthBits);
      end else if (stb.advance) begin
        unique case (stb.lgLanes)
          2'd0:    txSh <= txSh << 1;
          2'd1:    txSh <= txSh << 2;
          default: txSh <= txSh << 4;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_rxOut
    assign rxWords[g*WORD_W +: WORD_W] = rxReg[g];
  end

  logic unusedBits;
  assign unusedBits = ^laneBits;
endmodule

// File: rtl/lane_burst_shifter.sv
module lane_burst_shifter
  import lbs_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        go,
  input  logic [NUM_WORDS*WORD_W-1:0] txWords,
  input  logic [1:0]                  widthSel,
  input  logic [IDX_W-1:0]            wordCnt,
  input  logic [1:0]                  laneMode,
  input  logic                        dirIn,
  input  logic                        csEnable,
  input  logic                        csActiveHigh,
  input  logic [DIV_W-1:0]            clkDiv,
  output logic                        busy,
  output logic [NUM_WORDS*WORD_W-1:0] rxWords,
  output logic                        csOut,
  output logic                        sclk,
  output logic [LANES-1:0]            dataOut,
  output logic [LANES-1:0]            dataOe,
  input  logic [LANES-1:0]            dataIn
);
  lbs_strobe_t stb;

  lbs_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .widthSel(widthSel), .wordCnt(wordCnt),
    .laneMode(laneMode), .dirIn(dirIn), .clkDiv(clkDiv), .csEnable(csEnable),
    .csActiveHigh(csActiveHigh), .stb(stb), .busy(busy), .sclk(sclk), .csOut(csOut)
  );

  lbs_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .txWords(txWords),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .rxWords(rxWords)
  );
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker
  import lbs_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        go,
  input logic                        busy,
  input logic                        sclk,
  input logic [LANES-1:0]            dataOe,
  input logic                        csOut,
  input logic                        csEnable,
  input logic                        csActiveHigh,
  input logic [NUM_WORDS*WORD_W-1:0] rxWords
);
  // R2
  go_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(go));
  // R7
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> dataOe == 4'b0000);
  // R5
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe == 4'b0000) || (dataOe == 4'b0001) || (dataOe == 4'b0011) || (dataOe == 4'b1111));
  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);
  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(rxWords));
  // R9
  cs_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> csOut == ($past(csActiveHigh) ? $past(csEnable) : !$past(csEnable)));
endmodule

bind lane_burst_shifter lbs_checker u_chk (
  .clk(clk), .rstN(rstN), .go(go), .busy(busy), .sclk(sclk), .dataOe(dataOe),
  .csOut(csOut), .csEnable(csEnable), .csActiveHigh(csActiveHigh), .rxWords(rxWords)
);

// File: tb/lane_burst_shifter_test.sv
module lane_burst_shifter_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0, rstN = 1'b0, go = 1'b0;
  logic [127:0] txWords = '0;
  logic [1:0]   widthSel = 2'd3, wordCnt = 2'd0, laneMode = 2'd0;
  logic         dirIn = 1'b0, csEnable = 1'b0, csActiveHigh = 1'b0;
  logic [7:0]   clkDiv = 8'd1;
  logic         busy, csOut, sclk;
  logic [127:0] rxWords;
  logic [3:0]   dataOut, dataOe;
  logic [3:0]   dataIn = 4'h0;

  int checks = 0, fails = 0;
  int curLg = 0, curWidth = 32;
  bit curDirIn = 1'b0;
  int sclkRises = 0;
  logic [31:0] expQ[$];
  logic [31:0] slaveQ[$];
  logic [31:0] capAcc, slvSh;
  int capBits = 0, slvBits = 0;

  lane_burst_shifter uut (
    .clk(clk), .rstN(rstN), .go(go), .txWords(txWords), .widthSel(widthSel),
    .wordCnt(wordCnt), .laneMode(laneMode), .dirIn(dirIn), .csEnable(csEnable),
    .csActiveHigh(csActiveHigh), .clkDiv(clkDiv), .busy(busy), .rxWords(rxWords),
    .csOut(csOut), .sclk(sclk), .dataOut(dataOut), .dataOe(dataOe), .dataIn(dataIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rxAt(input int i);
    return rxWords[i*32 +: 32];
  endfunction

  // flash-side model: present bits from slaveQ after each falling sclk
  task automatic slavePresent();
    if (!curDirIn) begin
      dataIn = 4'h0;
      return;
    end
    if (slvBits == 0) begin
      slvSh   = (slaveQ.size() > 0) ? (slaveQ.pop_front() << (32 - curWidth)) : 32'h0;
      slvBits = curWidth;
    end
    case (curLg)
      0:       begin dataIn = {2'b11, slvSh[31], 1'b1}; slvSh = slvSh << 1; slvBits -= 1; end
      1:       begin dataIn = {2'b11, slvSh[31:30]};    slvSh = slvSh << 2; slvBits -= 2; end
      default: begin dataIn = slvSh[31:28];             slvSh = slvSh << 4; slvBits -= 4; end
    endcase
  endtask

  always @(posedge busy) begin
    #1;
    capBits = 0;
    capAcc  = 0;
    slvBits = 0;
    slavePresent();
  end

  always @(negedge sclk) begin
    #1;
    if (busy) slavePresent();
  end

  // monitor: capture transmitted words and compare against the scoreboard
  always @(posedge sclk) begin
    if (busy) sclkRises++;
    if (busy && !curDirIn) begin
      case (curLg)
        0:       begin capAcc = {capAcc[30:0], dataOut[0]};   capBits += 1; end
        1:       begin capAcc = {capAcc[29:0], dataOut[1:0]}; capBits += 2; end
        default: begin capAcc = {capAcc[27:0], dataOut};      capBits += 4; end
      endcase
      if (capBits == curWidth) begin
        if (expQ.size() == 0) chk("R3 unexpected word", capAcc, 32'hxxxxxxxx);
        else                  chk("R3/R4/R5 tx word", capAcc, expQ.pop_front());
        capBits = 0;
        capAcc  = 0;
      end
    end
  end

  task automatic runBurst(input logic [1:0] ws, input logic [1:0] cnt, input logic [1:0] lm,
                          input bit din, input logic [7:0] dv, input bit interfere,
                          input string req);
    int cycles, beats, expCycles;
    logic [3:0] orOe, expOe;
    @(negedge clk);
    widthSel = ws; wordCnt = cnt; laneMode = lm; dirIn = din; clkDiv = dv;
    curLg = (lm == 2'd0) ? 0 : (lm == 2'd1) ? 1 : 2;
    curWidth = (int'(ws) + 1) * 8;
    curDirIn = din;
    sclkRises = 0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    cycles = 0;
    orOe = '0;
    while (busy && cycles < 5000) begin
      cycles++;
      orOe |= dataOe;
      @(negedge clk);
      if (interfere && cycles == 3) begin
        go = 1'b1; widthSel = 2'd0; laneMode = 2'd0; dirIn = ~din; wordCnt = 2'd3;
      end else begin
        go = 1'b0;
      end
    end
    go = 1'b0;
    beats = ((int'(cnt) + 1) * curWidth) >> curLg;
    expCycles = (dv == 0) ? beats : beats * 2 * int'(dv);
    expOe = din ? 4'h0 : (curLg == 0) ? 4'b0001 : (curLg == 1) ? 4'b0011 : 4'b1111;
    chk({req, " R2 busy cycles"}, cycles, expCycles);
    chk({req, " R8 sclk rises"}, sclkRises, beats);
    chk({req, " R7 dataOe"}, {28'h0, orOe}, {28'h0, expOe});
    chk({req, " R3 scoreboard drained"}, expQ.size(), 0);
    widthSel = ws; wordCnt = cnt; laneMode = lm; dirIn = din;
  endtask

  localparam logic [31:0] T0 = 32'h0BAD_F00D, T1 = 32'hDEAD_BEEF;
  localparam logic [31:0] T2 = 32'h1234_5678, T3 = 32'hA5C3_0F96;

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=idle");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    txWords = {T3, T2, T1, T0};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 csOut", csOut, 1);
    chk("R1 dataOe", dataOe, 0);
    for (int i = 0; i < 4; i++) chk("R1 rx", rxAt(i), 0);

    // R3 single lane, four 32-bit words, highest index first
    expQ.push_back(T3); expQ.push_back(T2); expQ.push_back(T1); expQ.push_back(T0);
    runBurst(2'd3, 2'd3, 2'd0, 1'b0, 8'd1, 1'b0, "single32x4");

    // R4 R5 dual lane, two 16-bit words
    expQ.push_back(T1 & 32'hFFFF); expQ.push_back(T0 & 32'hFFFF);
    runBurst(2'd1, 2'd1, 2'd1, 1'b0, 8'd2, 1'b0, "dual16x2");

    // R8 quad lane, one 24-bit word, undivided clock
    expQ.push_back(T0 & 32'hFF_FFFF);
    runBurst(2'd2, 2'd0, 2'd2, 1'b0, 8'd0, 1'b0, "quad24div0");

    // R6 quad input, three words
    slaveQ.push_back(32'hCAFE_0001); slaveQ.push_back(32'h7654_3210); slaveQ.push_back(32'h8899_AABB);
    runBurst(2'd3, 2'd2, 2'd3, 1'b1, 8'd1, 1'b0, "quadIn32x3");
    chk("R6 rx2", rxAt(2), 32'hCAFE_0001);
    chk("R6 rx1", rxAt(1), 32'h7654_3210);
    chk("R6 rx0", rxAt(0), 32'h8899_AABB);
    chk("R6 rx3 untouched", rxAt(3), 32'h0);

    // R5 single input samples line 1 only
    slaveQ.push_back(32'h9C);
    runBurst(2'd0, 2'd0, 2'd0, 1'b1, 8'd3, 1'b0, "singleIn8");
    chk("R5 rx0 single line1", rxAt(0), 32'h0000_009C);
    chk("R6 rx1 untouched", rxAt(1), 32'h7654_3210);

    // R6 dual input, two 24-bit words, undivided clock
    slaveQ.push_back(32'h13_579B); slaveQ.push_back(32'hFE_DCBA);
    runBurst(2'd2, 2'd1, 2'd1, 1'b1, 8'd0, 1'b0, "dualIn24x2");
    chk("R6 rx1 dual", rxAt(1), 32'h0013_579B);
    chk("R6 rx0 dual", rxAt(0), 32'h00FE_DCBA);
    chk("R6 rx2 kept", rxAt(2), 32'hCAFE_0001);

    // R7 output burst leaves receive words alone
    expQ.push_back(T0 & 32'hFF);
    runBurst(2'd0, 2'd0, 2'd0, 1'b0, 8'd1, 1'b0, "single8");
    chk("R7 rx3 kept", rxAt(3), 32'h0);
    chk("R7 rx2 kept", rxAt(2), 32'hCAFE_0001);
    chk("R7 rx1 kept", rxAt(1), 32'h0013_579B);
    chk("R7 rx0 kept", rxAt(0), 32'h00FE_DCBA);

    // R2 go during a burst is ignored
    expQ.push_back(T0);
    runBurst(2'd3, 2'd0, 2'd2, 1'b0, 8'd2, 1'b1, "quad32busyGo");
    repeat (4) @(negedge clk);
    chk("R2 no restart after ignored go", busy, 0);

    // R9 chip select held across bursts
    csEnable = 1'b1;
    @(negedge clk);
    chk("R9 cs active low", csOut, 0);
    expQ.push_back(T0 & 32'hFF);
    runBurst(2'd0, 2'd0, 2'd2, 1'b0, 8'd1, 1'b0, "csSpan");
    chk("R9 cs held after burst", csOut, 0);
    csEnable = 1'b0;
    @(negedge clk);
    chk("R9 cs released", csOut, 1);
    csActiveHigh = 1'b1;
    csEnable = 1'b1;
    @(negedge clk);
    chk("R9 cs active high", csOut, 1);
    csEnable = 1'b0;
    @(negedge clk);
    chk("R9 cs high-polarity release", csOut, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule